// File: doc/BRIEF.md
# Packed Byte Signed-Count Rotator

This block is a SIMD datapath that splits a 128-bit operand into sixteen byte lanes and rotates each lane on its own. The amount comes either from one shared 8-bit immediate or from a second 128-bit vector that supplies one count byte per lane. Every count is a signed two's-complement value. Its sign sets the direction: a positive count rotates toward the MSB and a negative count rotates toward the LSB. The count is applied modulo the lane width.

In variable mode, a role input selects which of the two 128-bit inputs holds the data and which holds the counts. The output is a 256-bit destination view. Its lower half carries the rotated lanes and its upper half is always zero.

With the default parameters the result sits behind one output register with a valid-in/valid-out pair. A parameter can remove that register and make the path combinational. The block produces no flags or status.

Top module: `pbr_rotator`

## Requirements
- R1: Lane i occupies bits [8i+7:8i] of every vector. Lane i of the result depends only on data lane i and the count for lane i, so a lane with zero data yields zero whatever the other lanes hold.
- R2: A positive count k rotates the lane left by k: bit j moves to bit (j+k) mod 8, and bits leaving bit 7 re-enter at bit 0.
- R3: A negative count -k rotates the lane right by k: bit j moves to bit (j-k) mod 8, and bits leaving bit 0 re-enter at bit 7.
- R4: The effective amount is the count modulo 8. A count of 0, ±8 or -128 leaves the lane unchanged. A count of 127 acts as a left rotate by 7, and -1 acts as a left rotate by 7.
- R5: With fixed_mode_i=1, imm_i is the count for all sixteen lanes and opnd_b_i is the data. opnd_a_i and swap_i have no effect.
- R6: With fixed_mode_i=0 and swap_i=0, opnd_a_i is the count vector (byte i counts lane i) and opnd_b_i is the data.
- R7: With fixed_mode_i=0 and swap_i=1, opnd_a_i is the data and opnd_b_i is the count vector.
- R8: result_o[255:128] is zero at all times.
- R9: With REG_OUT=1, valid_o equals valid_i from the previous cycle. The result of a cycle with valid_i=1 appears one cycle later. When valid_i=0, result_o holds its value.
- R10: While rst_ni is low, valid_o is 0 and result_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid this cycle |
| fixed_mode_i | input | 1 | 1: shared immediate count, 0: per-lane count vector |
| swap_i | input | 1 | Operand roles in variable mode (0: a counts, b data; 1: a data, b counts) |
| opnd_a_i | input | 128 | First operand |
| opnd_b_i | input | 128 | Second operand |
| imm_i | input | 8 | Signed shared count |
| valid_o | output | 1 | Result valid |
| result_o | output | 256 | Rotated lanes in [127:0], zeros in [255:128] |

## Verification
The bench builds the block with its default parameters: sixteen 8-bit lanes and REG_OUT=1. This puts the one-cycle latency, the hold on idle cycles and the reset values within reach, as well as the three-bit modulo reduction of counts. The shared immediate is swept through 0, ±1, ±7, ±8, 127 and -128. The same boundary values are spread across the lanes of the count vector under both role settings. A single-lane data pattern exposes any leakage between lanes.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  typedef enum logic {
    ROLE_A_CNT  = 1'b0,
    ROLE_A_DATA = 1'b1
  } role_e;
endpackage

// File: rtl/pbr_lane_rot.sv
module pbr_lane_rot #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] data_i,
  input  logic [LANE_W-1:0] cnt_i,
  output logic [LANE_W-1:0] res_o
);
  localparam int unsigned SH_W = $clog2(LANE_W);

  logic [SH_W-1:0]     amt;
  logic [2*LANE_W-1:0] dbl;

  // low bits of two's complement count = left amount mod LANE_W
  assign amt   = cnt_i[SH_W-1:0];
  assign dbl   = {data_i, data_i} << amt;
  assign res_o = dbl[2*LANE_W-1:LANE_W];

  always_comb begin
    AST_ONES_KEPT: assert ($countones(res_o) == $countones(data_i)); // R2
    if (amt == '0)
      AST_ZERO_AMT: assert (res_o == data_i); // R4
  end
endmodule

// File: rtl/pbr_opsel.sv
module pbr_opsel
  import pbr_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic                     fixed_mode_i,
  input  role_e                    role_i,
  input  logic [LANES*LANE_W-1:0]  opnd_a_i,
  input  logic [LANES*LANE_W-1:0]  opnd_b_i,
  input  logic [LANE_W-1:0]        imm_i,
  output logic [LANES*LANE_W-1:0]  data_o,
  output logic [LANES*LANE_W-1:0]  cnt_o
);
  logic [LANES*LANE_W-1:0] imm_rep;

  for (genvar g = 0; g < LANES; g++) begin : g_rep
    assign imm_rep[g*LANE_W +: LANE_W] = imm_i;
  end

  always_comb begin
    if (fixed_mode_i) begin
      data_o = opnd_b_i;
      cnt_o  = imm_rep;
    end else if (role_i == ROLE_A_DATA) begin
      data_o = opnd_a_i;
      cnt_o  = opnd_b_i;
    end else begin
      data_o = opnd_b_i;
      cnt_o  = opnd_a_i;
    end
  end
endmodule

// File: rtl/pbr_rotator.sv
module pbr_rotator
  import pbr_pkg::*;
#(
  parameter int unsigned LANES   = 16,
  parameter int unsigned LANE_W  = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic                          fixed_mode_i,
  input  logic                          swap_i,
  input  logic [LANES*LANE_W-1:0]       opnd_a_i,
  input  logic [LANES*LANE_W-1:0]       opnd_b_i,
  input  logic [LANE_W-1:0]             imm_i,
  output logic                          valid_o,
  output logic [2*LANES*LANE_W-1:0]     result_o
);
  localparam int unsigned VEC_W = LANES * LANE_W;

  logic [VEC_W-1:0] data_v, cnt_v, rot_v, res_v;
  role_e            role;

  assign role = swap_i ? ROLE_A_DATA : ROLE_A_CNT;

  pbr_opsel #(.LANES(LANES), .LANE_W(LANE_W)) i_opsel (
    .fixed_mode_i (fixed_mode_i),
    .role_i       (role),
    .opnd_a_i     (opnd_a_i),
    .opnd_b_i     (opnd_b_i),
    .imm_i        (imm_i),
    .data_o       (data_v),
    .cnt_o        (cnt_v)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pbr_lane_rot #(.LANE_W(LANE_W)) i_lane (
      .data_i (data_v[g*LANE_W +: LANE_W]),
      .cnt_i  (cnt_v[g*LANE_W +: LANE_W]),
      .res_o  (rot_v[g*LANE_W +: LANE_W])
    );
  end

  if (REG_OUT) begin : g_reg
    logic             vld_q;
    logic [VEC_W-1:0] res_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else begin
        vld_q <= valid_i;
        if (valid_i) res_q <= rot_v;
      end
    end

    assign valid_o = vld_q;
    assign res_v   = res_q;

    AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == $past(valid_i)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(result_o)); // R9
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign valid_o    = valid_i;
    assign res_v      = rot_v;
  end

  assign result_o = {{VEC_W{1'b0}}, res_v};
endmodule

// File: tb/test_pbr_rotator.sv
`timescale 1ns/1ps
module test_pbr_rotator;
  localparam int LANES = 16;
  localparam int LW    = 8;
  localparam int VW    = LANES * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0, fixed_mode_i = 1'b0, swap_i = 1'b0;
  logic [VW-1:0] opnd_a_i = '0, opnd_b_i = '0;
  logic [7:0]    imm_i = '0;
  logic          valid_o;
  logic [2*VW-1:0] result_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [VW-1:0] last_exp = '0;

  always #2 clk = ~clk;

  pbr_rotator i_pbr_rotator (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .fixed_mode_i(fixed_mode_i),
    .swap_i(swap_i), .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i), .imm_i(imm_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [7:0] ref_rot(logic [7:0] d, logic [7:0] c);
    int n = int'($signed(c));
    logic [7:0] r = d;
    if (n > 0) repeat (n) r = {r[6:0], r[7]};
    else       repeat (-n) r = {r[0], r[7:1]};
    return r;
  endfunction

  function automatic logic [VW-1:0] ref_vec(logic [VW-1:0] d, logic [VW-1:0] c);
    logic [VW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*8 +: 8] = ref_rot(d[i*8 +: 8], c[i*8 +: 8]);
    return r;
  endfunction

  function automatic logic [VW-1:0] fill(logic [7:0] v);
    logic [VW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*8 +: 8] = v;
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(string tag, logic [2*VW-1:0] got, logic [2*VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  // one transaction; result checked after the capturing edge
  task automatic run(bit fx, bit sw, logic [VW-1:0] a, logic [VW-1:0] b,
                     logic [7:0] imm, string tag);
    logic [VW-1:0] exp;
    if (fx)      exp = ref_vec(b, fill(imm));
    else if (sw) exp = ref_vec(a, b);
    else         exp = ref_vec(b, a);
    @(negedge clk);
    valid_i = 1'b1; fixed_mode_i = fx; swap_i = sw;
    opnd_a_i = a; opnd_b_i = b; imm_i = imm;
    @(posedge clk); #1;
    chk(tag, result_o, {{VW{1'b0}}, exp});
    chk("R9 valid", {{(2*VW-1){1'b0}}, valid_o}, {{(2*VW-1){1'b0}}, 1'b1});
    last_exp = exp;
  endtask

  logic [7:0] bnd [10] = '{8'd0, 8'd1, 8'hFF, 8'd7, 8'hF9, 8'd8, 8'hF8, 8'd127, 8'h80, 8'd3};

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] cv, dv;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset result", result_o, '0);
    chk("R10 reset valid", {{(2*VW-1){1'b0}}, valid_o}, '0);
    @(negedge clk); rst_n = 1'b1;

    // fixed count sweep, R2 R3 R4 R5
    foreach (bnd[k]) run(1'b1, 1'b0, rnd_vec(), rnd_vec(), bnd[k], "R5 fixed R4 boundary");
    // fixed: swap and opnd_a ignored R5
    for (int k = 0; k < 6; k++) run(1'b1, 1'b1, rnd_vec(), rnd_vec(), 8'($urandom), "R5 swap ignored");
    run(1'b1, 1'b0, '0, {VW/8{8'h81}}, 8'd1, "R2 left wrap");
    run(1'b1, 1'b0, '0, {VW/8{8'h81}}, 8'hFF, "R3 right wrap");
    run(1'b1, 1'b0, '0, {VW/8{8'hA5}}, 8'h80, "R4 -128 unchanged");

    // variable, boundary counts spread over lanes
    for (int s = 0; s < 10; s++) begin
      for (int i = 0; i < LANES; i++) cv[i*8 +: 8] = bnd[(i + s) % 10];
      dv = rnd_vec();
      run(1'b0, 1'b0, cv, dv, 8'($urandom), "R6 R4 lane counts");
      run(1'b0, 1'b1, dv, cv, 8'($urandom), "R7 R4 lane counts");
    end
    for (int k = 0; k < 40; k++) begin
      run(1'b0, 1'b0, rnd_vec(), rnd_vec(), 8'($urandom), "R6 random");
      run(1'b0, 1'b1, rnd_vec(), rnd_vec(), 8'($urandom), "R7 random");
    end

    // lane independence R1
    for (int i = 0; i < LANES; i++) begin
      dv = '0; dv[i*8 +: 8] = 8'($urandom | 1);
      run(1'b0, 1'b0, rnd_vec(), dv, 8'd0, "R1 isolation");
    end

    // idle hold R9
    @(negedge clk);
    valid_i = 1'b0; opnd_a_i = rnd_vec(); opnd_b_i = rnd_vec(); imm_i = 8'd3;
    @(posedge clk); #1;
    chk("R9 idle valid", {{(2*VW-1){1'b0}}, valid_o}, '0);
    chk("R9 hold", result_o, {{VW{1'b0}}, last_exp});
    @(posedge clk); #1;
    chk("R9 hold 2", result_o, {{VW{1'b0}}, last_exp});
    chk("R8 upper zero", {{VW{1'b0}}, result_o[2*VW-1:VW]}, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule